// File: doc/BRIEF.md
# Cascaded Multi-Domain Reset Tree

This block turns one active-low power-on input per power domain into a tree of active-low resets. In the always-on clock, each domain's power-on input is first stretched. The stretched reset is released only after the input has stayed high for a programmable number of cycles. The stretched reset then releases per-clock power-on resets through two-flop synchronizers. These synchronizers assert at once and release on the clock edge.

Each domain has a life-cycle root reset and a system root reset:

- **Life-cycle root:** released from the always-on domain's peripheral-clock power-on reset. A per-domain life-cycle request can hold it low.
- **System root:** released from that domain's life-cycle root. A per-domain system request can hold it low.
- **Leaves:** each leaf reset follows one of the two roots, synchronized to its own clock. One leaf exists only in the always-on domain. In every other domain that leaf is tied low for good.

A scan override replaces the stretched reset with the scan reset input while scan mode is on. The whole tree below it then follows the scan reset.

Top module: `rst_cascade_tree`

## Requirements
- R1: When scan mode is off and a domain's power-on input is low, that domain's always-on reset output is low in the same cycle, with no clock edge needed.
- R2: With scan mode off, the always-on reset output of a domain goes high at the STRETCH+2-th always-on clock rising edge after that domain's power-on input goes high. The input must stay high at every one of those edges. Any low period restarts the count from zero.
- R3: While scan mode is high (1), the always-on reset of every domain equals the scan reset input. Everything below it follows that value.
- R4: Each domain's system-clock and peripheral-clock power-on resets fall together with the domain's always-on reset. Each rises at the second rising edge of its own clock after the always-on reset is high.
- R5: The life-cycle root reset of domain d is low whenever either of these holds:
  - the always-on domain's (index AON_DOM) peripheral-clock power-on reset is low;
  - life-cycle request bit d is high.

  It rises at the second system-clock edge after that condition clears.
- R6: The system root reset of domain d is low whenever its life-cycle root is low or system request bit d is high. It rises at the second system-clock edge after that condition clears.
- R7: The life-cycle leaf and the system leaf of each domain follow, respectively, the life-cycle root and the system root of that domain. Each falls together with its root and rises at the second peripheral-clock edge after the root is high.
- R8: The always-on-only leaf follows the system root of domain AON_DOM in the always-on clock, falling together with it and rising two edges after it is high. In every other domain the output is constantly low.
- R9: No reset in the cascade rises unless the reset (and request condition) directly above it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon_i | input | 1 | Always-on clock |
| clk_sys_i | input | 1 | System clock (roots and system power-on reset) |
| clk_periph_i | input | 1 | Peripheral clock (leaves and peripheral power-on reset) |
| por_n_i | input | NUM_DOMAINS | Raw power-on reset per domain, active low |
| scan_mode_i | input | 1 | Scan mode enable, high = on |
| scan_rst_ni | input | 1 | Scan reset, active low |
| lc_req_i | input | NUM_DOMAINS | Life-cycle reset request per domain, high = hold |
| sys_req_i | input | NUM_DOMAINS | System reset request per domain, high = hold |
| rst_por_aon_n_o | output | NUM_DOMAINS | Stretched always-on power-on reset |
| rst_por_n_o | output | NUM_DOMAINS | Power-on reset in the system clock |
| rst_por_periph_n_o | output | NUM_DOMAINS | Power-on reset in the peripheral clock |
| rst_lc_src_n_o | output | NUM_DOMAINS | Life-cycle root reset |
| rst_sys_src_n_o | output | NUM_DOMAINS | System root reset |
| rst_lc_leaf_n_o | output | NUM_DOMAINS | Life-cycle leaf reset, peripheral clock |
| rst_sys_leaf_n_o | output | NUM_DOMAINS | System leaf reset, peripheral clock |
| rst_aon_only_n_o | output | NUM_DOMAINS | System leaf in the always-on clock, AON_DOM only |

## Verification
The tree is first released from a full power-on. This shows the stretch length and the two-edge release of every stage in order. A power-on glitch during the stretch count shows whether the counter restarts or only pauses. Power-on loss in only the non-always-on domain is then compared with loss in the always-on domain. That comparison tells the per-domain chains apart from the shared life-cycle source. Life-cycle and system requests are pulsed one at a time, and scan mode is toggled both with the scan reset low and with it high. This separates request holding, scan override and the order of release.

// File: rtl/rtree_pkg.sv
package rtree_pkg;

  // Flops per reset synchronizer.
  localparam int unsigned SyncDepth = 2;

  // Counter width able to hold values 0 .. n-1.
  function automatic int unsigned cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rtree_sync.sv
module rtree_sync #(
  parameter int unsigned DEPTH = rtree_pkg::SyncDepth
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [DEPTH-1:0] q_q;
  logic [DEPTH-1:0] q_d;

  always_comb begin
    q_d = {q_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      q_q <= '0;
    end else begin
      q_q <= q_d;
    end
  end

  assign rst_no = q_q[DEPTH-1];

endmodule

// File: rtl/rtree_stretch.sv
module rtree_stretch #(
  parameter int unsigned STRETCH = 8
) (
  input  logic clk_i,
  input  logic por_ni,
  output logic rst_no
);

  localparam int unsigned CW = rtree_pkg::cnt_width(STRETCH);
  localparam logic [CW-1:0] LastCnt = CW'(STRETCH - 1);

  logic          por_sync;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_en;

  rtree_sync u_por_sync (
    .clk_i  (clk_i),
    .arst_ni(por_ni),
    .rst_no (por_sync)
  );

  always_comb begin
    cnt_en = por_sync && !done_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    if (cnt_en) begin
      if (cnt_q == LastCnt) begin
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign rst_no = done_q;

endmodule

// File: rtl/rst_cascade_tree.sv
module rst_cascade_tree #(
  parameter int unsigned NUM_DOMAINS = 2,
  parameter int unsigned AON_DOM     = 0,
  parameter int unsigned STRETCH     = 8
) (
  input  logic                   clk_aon_i,
  input  logic                   clk_sys_i,
  input  logic                   clk_periph_i,
  input  logic [NUM_DOMAINS-1:0] por_n_i,
  input  logic                   scan_mode_i,
  input  logic                   scan_rst_ni,
  input  logic [NUM_DOMAINS-1:0] lc_req_i,
  input  logic [NUM_DOMAINS-1:0] sys_req_i,
  output logic [NUM_DOMAINS-1:0] rst_por_aon_n_o,
  output logic [NUM_DOMAINS-1:0] rst_por_n_o,
  output logic [NUM_DOMAINS-1:0] rst_por_periph_n_o,
  output logic [NUM_DOMAINS-1:0] rst_lc_src_n_o,
  output logic [NUM_DOMAINS-1:0] rst_sys_src_n_o,
  output logic [NUM_DOMAINS-1:0] rst_lc_leaf_n_o,
  output logic [NUM_DOMAINS-1:0] rst_sys_leaf_n_o,
  output logic [NUM_DOMAINS-1:0] rst_aon_only_n_o
);

  logic [NUM_DOMAINS-1:0] stretched_n;
  logic [NUM_DOMAINS-1:0] eff_aon_n;
  logic [NUM_DOMAINS-1:0] lc_arst_n;
  logic [NUM_DOMAINS-1:0] sys_arst_n;

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_por
    rtree_stretch #(.STRETCH(STRETCH)) u_stretch (
      .clk_i (clk_aon_i),
      .por_ni(por_n_i[d]),
      .rst_no(stretched_n[d])
    );

    // Scan reset sits at the same level as the stretched power-on reset.
    assign eff_aon_n[d] = scan_mode_i ? scan_rst_ni : stretched_n[d];

    rtree_sync u_por_sys (
      .clk_i  (clk_sys_i),
      .arst_ni(eff_aon_n[d]),
      .rst_no (rst_por_n_o[d])
    );

    rtree_sync u_por_periph (
      .clk_i  (clk_periph_i),
      .arst_ni(eff_aon_n[d]),
      .rst_no (rst_por_periph_n_o[d])
    );
  end

  assign rst_por_aon_n_o = eff_aon_n;

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_root
    assign lc_arst_n[d]  = rst_por_periph_n_o[AON_DOM] && !lc_req_i[d];
    assign sys_arst_n[d] = rst_lc_src_n_o[d] && !sys_req_i[d];

    rtree_sync u_lc_root (
      .clk_i  (clk_sys_i),
      .arst_ni(lc_arst_n[d]),
      .rst_no (rst_lc_src_n_o[d])
    );

    rtree_sync u_sys_root (
      .clk_i  (clk_sys_i),
      .arst_ni(sys_arst_n[d]),
      .rst_no (rst_sys_src_n_o[d])
    );

    rtree_sync u_lc_leaf (
      .clk_i  (clk_periph_i),
      .arst_ni(rst_lc_src_n_o[d]),
      .rst_no (rst_lc_leaf_n_o[d])
    );

    rtree_sync u_sys_leaf (
      .clk_i  (clk_periph_i),
      .arst_ni(rst_sys_src_n_o[d]),
      .rst_no (rst_sys_leaf_n_o[d])
    );

    if (d == AON_DOM) begin : g_aon_leaf
      rtree_sync u_aon_leaf (
        .clk_i  (clk_aon_i),
        .arst_ni(rst_sys_src_n_o[d]),
        .rst_no (rst_aon_only_n_o[d])
      );
    end else begin : g_no_leaf
      // Leaf not implemented in this domain: held in reset.
      assign rst_aon_only_n_o[d] = 1'b0;
    end
  end

endmodule

// File: rtl/rst_cascade_tree_chk.sv
module rst_cascade_tree_chk #(
  parameter int unsigned NUM_DOMAINS = 2,
  parameter int unsigned AON_DOM     = 0,
  parameter int unsigned STRETCH     = 8
) (
  input logic                   clk_aon_i,
  input logic                   clk_sys_i,
  input logic                   clk_periph_i,
  input logic [NUM_DOMAINS-1:0] por_n_i,
  input logic                   scan_mode_i,
  input logic [NUM_DOMAINS-1:0] lc_req_i,
  input logic [NUM_DOMAINS-1:0] sys_req_i,
  input logic [NUM_DOMAINS-1:0] rst_por_aon_n_o,
  input logic [NUM_DOMAINS-1:0] rst_por_n_o,
  input logic [NUM_DOMAINS-1:0] rst_por_periph_n_o,
  input logic [NUM_DOMAINS-1:0] rst_lc_src_n_o,
  input logic [NUM_DOMAINS-1:0] rst_sys_src_n_o,
  input logic [NUM_DOMAINS-1:0] rst_lc_leaf_n_o,
  input logic [NUM_DOMAINS-1:0] rst_sys_leaf_n_o
);

  localparam int unsigned HiLimit = STRETCH + 4;

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_chk
    int unsigned hi_q;

    always_ff @(posedge clk_aon_i) begin
      if (!por_n_i[d]) begin
        hi_q <= 0;
      end else if (hi_q < HiLimit) begin
        hi_q <= hi_q + 1;
      end
    end

    // R1
    por_fall_chk: assert property (@(posedge clk_aon_i) disable iff (scan_mode_i)
      !por_n_i[d] |-> !rst_por_aon_n_o[d]);

    // R2
    stretch_len_chk: assert property (@(posedge clk_aon_i) disable iff (scan_mode_i)
      ($rose(rst_por_aon_n_o[d]) && !$past(scan_mode_i)) |-> (hi_q >= STRETCH + 2));

    // R4
    por_sys_rise_chk: assert property (@(posedge clk_sys_i) disable iff (scan_mode_i)
      $rose(rst_por_n_o[d]) |-> $past(rst_por_aon_n_o[d]));

    // R5
    lc_hold_chk: assert property (@(posedge clk_sys_i) disable iff (scan_mode_i)
      (!rst_por_periph_n_o[AON_DOM] || lc_req_i[d]) |-> !rst_lc_src_n_o[d]);

    // R5
    lc_rise_chk: assert property (@(posedge clk_sys_i) disable iff (scan_mode_i)
      $rose(rst_lc_src_n_o[d]) |-> $past(rst_por_periph_n_o[AON_DOM] && !lc_req_i[d]));

    // R6
    sys_hold_chk: assert property (@(posedge clk_sys_i) disable iff (scan_mode_i)
      (!rst_lc_src_n_o[d] || sys_req_i[d]) |-> !rst_sys_src_n_o[d]);

    // R6
    sys_rise_chk: assert property (@(posedge clk_sys_i) disable iff (scan_mode_i)
      $rose(rst_sys_src_n_o[d]) |-> $past(rst_lc_src_n_o[d] && !sys_req_i[d]));

    // R9
    lc_leaf_order_chk: assert property (@(posedge clk_periph_i) disable iff (scan_mode_i)
      $rose(rst_lc_leaf_n_o[d]) |-> rst_lc_src_n_o[d]);

    // R9
    sys_leaf_order_chk: assert property (@(posedge clk_periph_i) disable iff (scan_mode_i)
      $rose(rst_sys_leaf_n_o[d]) |-> rst_sys_src_n_o[d]);
  end

endmodule

bind rst_cascade_tree rst_cascade_tree_chk #(
  .NUM_DOMAINS(NUM_DOMAINS),
  .AON_DOM    (AON_DOM),
  .STRETCH    (STRETCH)
) u_chk (.*);

// File: tb/rst_cascade_tree_tb.sv
`timescale 1ns/1ps
module rst_cascade_tree_tb;

  localparam int ND   = 2;
  localparam int AON  = 0;
  localparam int S    = 8;
  localparam int WDOG = 5000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [ND-1:0] por_n, lc_req, sys_req;
  logic scan_mode, scan_rst_n;
  logic [ND-1:0] o_aon, o_por, o_pio, o_lc, o_sys, o_ll, o_sl, o_ao;

  rst_cascade_tree #(.NUM_DOMAINS(ND), .AON_DOM(AON), .STRETCH(S)) u_dut (
    .clk_aon_i         (clk),
    .clk_sys_i         (clk),
    .clk_periph_i      (clk),
    .por_n_i           (por_n),
    .scan_mode_i       (scan_mode),
    .scan_rst_ni       (scan_rst_n),
    .lc_req_i          (lc_req),
    .sys_req_i         (sys_req),
    .rst_por_aon_n_o   (o_aon),
    .rst_por_n_o       (o_por),
    .rst_por_periph_n_o(o_pio),
    .rst_lc_src_n_o    (o_lc),
    .rst_sys_src_n_o   (o_sys),
    .rst_lc_leaf_n_o   (o_ll),
    .rst_sys_leaf_n_o  (o_sl),
    .rst_aon_only_n_o  (o_ao)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural model: edge counters per stage, cleared while a stage is held.
  int hi[ND], c_por[ND], c_pio[ND], c_lc[ND], c_sys[ND], c_ll[ND], c_sl[ND], c_ao[ND];
  logic [ND-1:0] m_aon, m_por, m_pio, m_lc, m_sys, m_ll, m_sl, m_ao;

  function automatic int inc(logic r, int c);
    if (!r) return 0;
    return (c >= 2) ? 2 : c + 1;
  endfunction

  task automatic settle();
    for (int d = 0; d < ND; d++) begin
      if (!por_n[d]) hi[d] = 0;
      m_aon[d] = scan_mode ? scan_rst_n : (por_n[d] && hi[d] >= S + 2);
      if (!m_aon[d]) begin c_por[d] = 0; c_pio[d] = 0; end
      m_por[d] = m_aon[d] && c_por[d] >= 2;
      m_pio[d] = m_aon[d] && c_pio[d] >= 2;
    end
    for (int d = 0; d < ND; d++) begin
      if (!(m_pio[AON] && !lc_req[d])) c_lc[d] = 0;
      m_lc[d] = m_pio[AON] && !lc_req[d] && c_lc[d] >= 2;
      if (!(m_lc[d] && !sys_req[d])) c_sys[d] = 0;
      m_sys[d] = m_lc[d] && !sys_req[d] && c_sys[d] >= 2;
      if (!m_lc[d]) c_ll[d] = 0;
      m_ll[d] = m_lc[d] && c_ll[d] >= 2;
      if (!m_sys[d]) c_sl[d] = 0;
      m_sl[d] = m_sys[d] && c_sl[d] >= 2;
      if (!m_sys[d]) c_ao[d] = 0;
      m_ao[d] = (d == AON) && m_sys[d] && c_ao[d] >= 2;
    end
  endtask

  task automatic step();
    for (int d = 0; d < ND; d++) begin
      hi[d]    = por_n[d] ? ((hi[d] > 1000) ? hi[d] : hi[d] + 1) : 0;
      c_por[d] = inc(m_aon[d], c_por[d]);
      c_pio[d] = inc(m_aon[d], c_pio[d]);
      c_lc[d]  = inc(m_pio[AON] && !lc_req[d], c_lc[d]);
      c_sys[d] = inc(m_lc[d] && !sys_req[d], c_sys[d]);
      c_ll[d]  = inc(m_lc[d], c_ll[d]);
      c_sl[d]  = inc(m_sys[d], c_sl[d]);
      c_ao[d]  = inc(m_sys[d], c_ao[d]);
    end
    settle();
  endtask

  task automatic chk(string tag, logic [ND-1:0] act, logic [ND-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [ND-1:0] bad;
    chk("R1/R2/R3 aon reset", o_aon, m_aon);
    chk("R4 sys-clock por reset", o_por, m_por);
    chk("R4 periph-clock por reset", o_pio, m_pio);
    chk("R5 life-cycle root", o_lc, m_lc);
    chk("R6 system root", o_sys, m_sys);
    chk("R7 life-cycle leaf", o_ll, m_ll);
    chk("R7 system leaf", o_sl, m_sl);
    chk("R8 aon-only leaf", o_ao, m_ao);
    // R9: a lower reset is high only while the one above it is high.
    bad = '0;
    for (int d = 0; d < ND; d++) begin
      if (o_por[d] && !o_aon[d]) bad[d] = 1'b1;
      if (o_lc[d] && !o_pio[AON]) bad[d] = 1'b1;
      if (o_sys[d] && !o_lc[d]) bad[d] = 1'b1;
      if ((o_ll[d] && !o_lc[d]) || (o_sl[d] && !o_sys[d])) bad[d] = 1'b1;
    end
    chk("R9 cascade order", bad, '0);
  endtask

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      step();
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic apply(logic [ND-1:0] p, logic [ND-1:0] l, logic [ND-1:0] s,
                       logic sm, logic sr);
    por_n = p; lc_req = l; sys_req = s; scan_mode = sm; scan_rst_n = sr;
    #1;
    settle();
    compare_all();
  endtask

  initial begin
    por_n = '0; lc_req = '0; sys_req = '0; scan_mode = 1'b0; scan_rst_n = 1'b1;
    for (int d = 0; d < ND; d++) begin
      hi[d] = 0; c_por[d] = 0; c_pio[d] = 0; c_lc[d] = 0;
      c_sys[d] = 0; c_ll[d] = 0; c_sl[d] = 0; c_ao[d] = 0;
    end
    #1;
    settle();
    @(negedge clk);
    // Reset state: everything held low (R1, R8).
    compare_all();
    tick(4);
    // Full power-on release: stretch then cascade (R2, R4-R8).
    apply('1, '0, '0, 1'b0, 1'b1);
    tick(22);
    // Glitch on always-on power-on during the stretch count (R1, R2 restart).
    apply(2'b10, '0, '0, 1'b0, 1'b1);
    tick(3);
    apply('1, '0, '0, 1'b0, 1'b1);
    tick(5);
    apply(2'b10, '0, '0, 1'b0, 1'b1);
    tick(1);
    apply('1, '0, '0, 1'b0, 1'b1);
    tick(22);
    // Only domain 1 loses power-on: life-cycle roots stay up (R4, R5).
    apply(2'b01, '0, '0, 1'b0, 1'b1);
    tick(4);
    apply('1, '0, '0, 1'b0, 1'b1);
    tick(20);
    // Life-cycle request on domain 1 (R5, R6, R7).
    apply('1, 2'b10, '0, 1'b0, 1'b1);
    tick(5);
    apply('1, '0, '0, 1'b0, 1'b1);
    tick(8);
    // System request on domain 0 (R6, R7, R8).
    apply('1, '0, 2'b01, 1'b0, 1'b1);
    tick(5);
    apply('1, '0, '0, 1'b0, 1'b1);
    tick(8);
    // Both requests together on both domains.
    apply('1, '1, '1, 1'b0, 1'b1);
    tick(3);
    apply('1, '0, '1, 1'b0, 1'b1);
    tick(4);
    apply('1, '0, '0, 1'b0, 1'b1);
    tick(8);
    // Scan override with scan reset low, then high (R3).
    apply('1, '0, '0, 1'b1, 1'b0);
    tick(5);
    apply('1, '0, '0, 1'b1, 1'b1);
    tick(8);
    // Scan reset releases the tree even with power-on low (R3).
    apply('0, '0, '0, 1'b1, 1'b1);
    tick(4);
    apply('0, '0, '0, 1'b0, 1'b1);
    tick(3);
    apply('1, '0, '0, 1'b0, 1'b1);
    tick(22);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule